// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator with Vector Lookup

This block decides which interrupt, if any, the processor should take next. Every cycle it compares the current processor priority level (a 5-bit value, 0 to 31) with all pending requests. It then reports the highest eligible level on a combinational output. Up to five kinds of source feed it:

- a halt line;
- a corrected-read error event;
- an interval clock tick;
- eight maskable device lines that share one hardware level;
- a set of software request bits for levels 1 to 15.

When the processor acknowledges a level with a one-cycle strobe, the block clears the request it is serving. In the next cycle it presents a registered 10-bit vector. For the shared device level, the device with the highest bit number wins. Its vector comes from a small lookup table inside the block. Each table entry is wider than a vector, and only its low 10 bits are used. An acknowledge at a level that no vectored source can own is reported as an unexpected interrupt.

Top module: `irq_prio_eval`

## Requirements
- R1: After reset, best_lvl is 0, vec_valid and unexp_irq are low, and no error, tick or device request is pending.
- R2: While halt_in is high, best_lvl equals HALT_LVL (default 0x1F), whatever the current level and other requests are.
- R3: A pulse on crd_evt sets an error flag. While the flag is set and cur_ipl < CRD_LVL (0x1A), best_lvl is CRD_LVL unless the halt line is high.
- R4: A pulse on tick_evt sets a clock flag. The flag wins next, giving CLK_LVL (0x16) when cur_ipl < CLK_LVL.
- R5: A rising edge on dev_irq[b] sets request bit b. The bit holds until it is acknowledged or cleared by a 1 in hw_clr[b]. A bit counts only when hw_mask[b] is also 1. It gives HW_LVL (0x14) when cur_ipl < HW_LVL and no higher source wins.
- R6: Otherwise, if cur_ipl < 15, best_lvl is the highest index i of sw_req with i > cur_ipl. Bit i stands for level i. If there is no such bit, or if cur_ipl >= 15, best_lvl is 0.
- R7: An acknowledge with ack_lvl == CRD_LVL clears the error flag and returns VEC_CRD (default 0x054).
- R8: An acknowledge with ack_lvl == CLK_LVL clears the clock flag and returns VEC_CLK (default 0x0C0).
- R9: Any other acknowledge with ack_lvl <= HW_MAX (0x17) serves the device bit. It picks the highest b with the request and mask bits both set, and clears that request. It returns table entry 8+b masked to 10 bits, which is VEC_BASE + 4*(8+b) (0x120 + 4*b by default). With no such bit it returns vector 0.
- R10: An acknowledge with ack_lvl above HW_MAX (other than CRD_LVL) raises unexp_irq for one cycle, leaves vec_valid low and clears nothing.
- R11: vec_valid is high in exactly the cycle after an accepted acknowledge strobe, and vec is 0 whenever vec_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ipl | input | 5 | Current processor priority level |
| halt_in | input | 1 | Halt line, highest precedence |
| crd_evt | input | 1 | Corrected-read error event pulse |
| tick_evt | input | 1 | Interval clock tick pulse |
| dev_irq | input | 8 | Device request lines, rising-edge captured |
| hw_mask | input | 8 | Enable mask for device requests |
| hw_clr | input | 8 | Clear strobes for device request bits |
| sw_req | input | 16 | Software request bits, bit i for level i |
| ack | input | 1 | Acknowledge strobe |
| ack_lvl | input | 5 | Level being acknowledged |
| best_lvl | output | 5 | Highest eligible pending level, 0 if none |
| vec_valid | output | 1 | Vector valid, cycle after acknowledge |
| vec | output | 10 | Interrupt vector |
| unexp_irq | output | 1 | Acknowledge at an unvectored level |

## Verification
The hardest state to reach is several device requests pending at once with only part of them unmasked. Reaching it also shows that repeated acknowledges drain the requests from the top bit down, skipping masked bits. The bench gets there by pulsing all eight device lines, applying a partial mask and then acknowledging the hardware level over and over until a zero vector appears. It then lifts the mask so that the skipped bits become visible. The ordering between fixed sources and software levels is swept over every current level, with the error, tick and device sources pending in turn and many software bit patterns.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;

    localparam int LVL_W = 5;

    // Index of the highest set bit in an 8-bit vector; found flag separate.
    function automatic logic [2:0] top_bit8(input logic [7:0] v);
        logic [2:0] idx;
        idx = '0;
        for (int i = 0; i < 8; i++) begin
            if (v[i]) idx = 3'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/irq_level_eval.sv
module irq_level_eval
    import irq_eval_pkg::*;
#(
    parameter logic [LVL_W-1:0] HALT_LVL = 5'h1F,
    parameter logic [LVL_W-1:0] CRD_LVL  = 5'h1A,
    parameter logic [LVL_W-1:0] CLK_LVL  = 5'h16,
    parameter logic [LVL_W-1:0] HW_LVL   = 5'h14,
    parameter int               SW_TOP   = 15
) (
    input  logic [LVL_W-1:0] cur_ipl,
    input  logic             halt_in,
    input  logic             crd_pend,
    input  logic             tick_pend,
    input  logic             hw_pend,
    input  logic [SW_TOP:0]  sw_req,
    output logic [LVL_W-1:0] lvl_o
);

    logic [LVL_W-1:0] sw_lvl;

    always_comb begin
        sw_lvl = '0;
        for (int i = 0; i <= SW_TOP; i++) begin
            if (sw_req[i] && (LVL_W'(i) > cur_ipl)) sw_lvl = LVL_W'(i);
        end
    end

    always_comb begin
        if (halt_in)
            lvl_o = HALT_LVL;
        else if (crd_pend && (cur_ipl < CRD_LVL))
            lvl_o = CRD_LVL;
        else if (tick_pend && (cur_ipl < CLK_LVL))
            lvl_o = CLK_LVL;
        else if (hw_pend && (cur_ipl < HW_LVL))
            lvl_o = HW_LVL;
        else if (cur_ipl >= LVL_W'(SW_TOP))
            lvl_o = '0;
        else
            lvl_o = sw_lvl;
    end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int          DEPTH    = 16,
    parameter logic [9:0]  VEC_BASE = 10'h100,
    localparam int         IDX_W    = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [9:0]       vec_o
);

    logic [31:0] entry [DEPTH];

    // Preloaded words: upper bits filled with ones, only the low 10 bits form a vector.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign entry[g] = {22'h3FFFFF, 10'(VEC_BASE + 10'(4 * g))};
    end

    logic [31:0] raw;
    logic        unused_hi;
    assign raw       = entry[idx_i];
    assign vec_o     = raw[9:0];
    assign unused_hi = ^raw[31:10];

endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval
    import irq_eval_pkg::*;
#(
    parameter int               NDEV     = 8,
    parameter logic [LVL_W-1:0] HALT_LVL = 5'h1F,
    parameter logic [LVL_W-1:0] CRD_LVL  = 5'h1A,
    parameter logic [LVL_W-1:0] CLK_LVL  = 5'h16,
    parameter logic [LVL_W-1:0] HW_LVL   = 5'h14,
    parameter logic [LVL_W-1:0] HW_MAX   = 5'h17,
    parameter logic [9:0]       VEC_CRD  = 10'h054,
    parameter logic [9:0]       VEC_CLK  = 10'h0C0,
    parameter logic [9:0]       VEC_BASE = 10'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [4:0]       cur_ipl,
    input  logic             halt_in,
    input  logic             crd_evt,
    input  logic             tick_evt,
    input  logic [7:0]       dev_irq,
    input  logic [7:0]       hw_mask,
    input  logic [7:0]       hw_clr,
    input  logic [15:0]      sw_req,
    input  logic             ack,
    input  logic [4:0]       ack_lvl,
    output logic [4:0]       best_lvl,
    output logic             vec_valid,
    output logic [9:0]       vec,
    output logic             unexp_irq
);

    localparam int SW_TOP    = 15;
    localparam int TBL_DEPTH = 2 * NDEV;
    localparam int TBL_W     = $clog2(TBL_DEPTH);

    typedef struct packed {
        logic [NDEV-1:0] hw_req;
        logic [NDEV-1:0] dev_prev;
        logic            crd;
        logic            tick;
        logic [9:0]      vec;
        logic            vec_valid;
        logic            unexp;
    } irq_state_t;

    irq_state_t st_d, st_q;

    logic [NDEV-1:0]  hw_live;
    logic [2:0]       hw_win;
    logic [9:0]       tbl_vec;
    logic [TBL_W-1:0] tbl_idx;

    assign hw_live = st_q.hw_req & hw_mask;
    assign hw_win  = top_bit8(hw_live);
    assign tbl_idx = TBL_W'(NDEV) + TBL_W'(hw_win);

    irq_level_eval #(
        .HALT_LVL (HALT_LVL),
        .CRD_LVL  (CRD_LVL),
        .CLK_LVL  (CLK_LVL),
        .HW_LVL   (HW_LVL),
        .SW_TOP   (SW_TOP)
    ) lvl_i (
        .cur_ipl   (cur_ipl),
        .halt_in   (halt_in),
        .crd_pend  (st_q.crd),
        .tick_pend (st_q.tick),
        .hw_pend   (|hw_live),
        .sw_req    (sw_req),
        .lvl_o     (best_lvl)
    );

    irq_vec_table #(
        .DEPTH    (TBL_DEPTH),
        .VEC_BASE (VEC_BASE)
    ) tbl_i (
        .idx_i (tbl_idx),
        .vec_o (tbl_vec)
    );

    always_comb begin
        st_d           = st_q;
        st_d.dev_prev  = dev_irq;
        st_d.vec       = '0;
        st_d.vec_valid = 1'b0;
        st_d.unexp     = 1'b0;
        st_d.hw_req    = st_q.hw_req & ~hw_clr;

        if (ack) begin
            if (ack_lvl == CRD_LVL) begin
                st_d.crd       = 1'b0;
                st_d.vec       = VEC_CRD;
                st_d.vec_valid = 1'b1;
            end else if (ack_lvl == CLK_LVL) begin
                st_d.tick      = 1'b0;
                st_d.vec       = VEC_CLK;
                st_d.vec_valid = 1'b1;
            end else if (ack_lvl > HW_MAX) begin
                st_d.unexp     = 1'b1;
            end else begin
                st_d.vec_valid = 1'b1;
                if (|hw_live) begin
                    st_d.hw_req[hw_win] = 1'b0;
                    st_d.vec            = tbl_vec;
                end
            end
        end

        // New events take effect after the clears of the same cycle.
        st_d.hw_req = st_d.hw_req | (dev_irq & ~st_q.dev_prev);
        if (crd_evt)  st_d.crd  = 1'b1;
        if (tick_evt) st_d.tick = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vec_valid = st_q.vec_valid;
    assign vec       = st_q.vec;
    assign unexp_irq = st_q.unexp;

endmodule

// File: rtl/irq_prio_eval_chk.sv
module irq_prio_eval_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] cur_ipl,
    input logic       halt_in,
    input logic       ack,
    input logic [4:0] ack_lvl,
    input logic [4:0] best_lvl,
    input logic       vec_valid,
    input logic [9:0] vec,
    input logic       unexp_irq
);

    // R2
    halt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_in |-> best_lvl == 5'h1F);

    // R6
    above_ipl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_in && best_lvl != 5'd0) |-> best_lvl > cur_ipl);

    // R7
    crd_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_lvl == 5'h1A) |=> (vec_valid && vec == 10'h054));

    // R10
    unexp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_lvl > 5'h17 && ack_lvl != 5'h1A) |=> (unexp_irq && !vec_valid));

    // R11
    valid_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack));

    // R11
    vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec == 10'd0);

    // R10
    unexp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(unexp_irq && vec_valid));

endmodule

bind irq_prio_eval irq_prio_eval_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_ipl   (cur_ipl),
    .halt_in   (halt_in),
    .ack       (ack),
    .ack_lvl   (ack_lvl),
    .best_lvl  (best_lvl),
    .vec_valid (vec_valid),
    .vec       (vec),
    .unexp_irq (unexp_irq)
);

// File: tb/irq_prio_eval_tb_top.sv
module irq_prio_eval_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  cur_ipl;
    logic        halt_in, crd_evt, tick_evt, ack;
    logic [7:0]  dev_irq, hw_mask, hw_clr;
    logic [15:0] sw_req;
    logic [4:0]  ack_lvl;
    logic [4:0]  best_lvl;
    logic        vec_valid, unexp_irq;
    logic [9:0]  vec;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    irq_prio_eval dut_i (
        .clk(clk), .rst_n(rst_n), .cur_ipl(cur_ipl), .halt_in(halt_in),
        .crd_evt(crd_evt), .tick_evt(tick_evt), .dev_irq(dev_irq),
        .hw_mask(hw_mask), .hw_clr(hw_clr), .sw_req(sw_req), .ack(ack),
        .ack_lvl(ack_lvl), .best_lvl(best_lvl), .vec_valid(vec_valid),
        .vec(vec), .unexp_irq(unexp_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected level from the requirement ordering.
    function automatic int exp_lvl(int ipl, bit h, bit c, bit t, bit hw, logic [15:0] sw);
        if (h) return 'h1F;
        if (c && ipl < 'h1A) return 'h1A;
        if (t && ipl < 'h16) return 'h16;
        if (hw && ipl < 'h14) return 'h14;
        if (ipl >= 15) return 0;
        for (int i = 15; i > ipl; i--) if (sw[i]) return i;
        return 0;
    endfunction

    // Ack: drive on a falling edge, sample the registered result one cycle later.
    task automatic do_ack(input int lvl, output int v, output int vv, output int ux);
        @(negedge clk);
        ack = 1'b1; ack_lvl = 5'(lvl);
        @(negedge clk);
        ack = 1'b0;
        v = int'(vec); vv = int'(vec_valid); ux = int'(unexp_irq);
    endtask

    task automatic pulse_dev(input logic [7:0] m);
        @(negedge clk); dev_irq = m;
        @(negedge clk); dev_irq = '0;
    endtask

    task automatic sweep(input string tag, bit c, bit t, bit hw, logic [15:0] sw);
        for (int ipl = 0; ipl < 32; ipl++) begin
            @(negedge clk); cur_ipl = 5'(ipl); sw_req = sw;
            #1 chk(tag, int'(best_lvl), exp_lvl(ipl, 1'b0, c, t, hw, sw));
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int v, vv, ux;
        rst_n = 0; cur_ipl = 0; halt_in = 0; crd_evt = 0; tick_evt = 0; ack = 0;
        dev_irq = 0; hw_mask = 8'hFF; hw_clr = 0; sw_req = 0; ack_lvl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk("R1 level", int'(best_lvl), 0);
        chk("R1 valid", int'(vec_valid), 0);
        chk("R1 unexp", int'(unexp_irq), 0);
        sweep("R1 nothing pending", 0, 0, 0, 16'h0);

        // R6 software patterns over every level
        for (int k = 0; k < 22; k++) begin
            logic [15:0] p;
            p = (k < 16) ? (16'h1 << k) : 16'((k * 40503) ^ (k << 7));
            sweep("R6 software", 0, 0, 0, p);
        end

        // R2 halt over every level with software noise
        for (int ipl = 0; ipl < 32; ipl++) begin
            @(negedge clk); halt_in = 1; cur_ipl = 5'(ipl); sw_req = 16'hFFFF;
            #1 chk("R2 halt", int'(best_lvl), 'h1F);
        end
        @(negedge clk); halt_in = 0; sw_req = 0;

        // R3 / R7 error flag
        @(negedge clk); crd_evt = 1; @(negedge clk); crd_evt = 0;
        sweep("R3 crd", 1, 0, 0, 16'h8002);
        do_ack('h1A, v, vv, ux);
        chk("R7 vec", v, 'h054); chk("R7 valid", vv, 1);
        @(negedge clk); #1 chk("R11 valid one cycle", int'(vec_valid), 0);
        sweep("R7 crd cleared", 0, 0, 0, 16'h0);

        // R4 / R8 clock flag, with error also pending
        @(negedge clk); tick_evt = 1; crd_evt = 1; @(negedge clk); tick_evt = 0; crd_evt = 0;
        sweep("R4 tick+crd", 1, 1, 0, 16'h0400);
        do_ack('h1A, v, vv, ux);
        sweep("R4 tick", 0, 1, 0, 16'h0400);
        do_ack('h16, v, vv, ux);
        chk("R8 vec", v, 'h0C0); chk("R8 valid", vv, 1);
        sweep("R8 tick cleared", 0, 0, 0, 16'h0400);

        // R5 each device bit alone, mask on/off, clear
        for (int b = 0; b < 8; b++) begin
            hw_mask = 8'hFF;
            pulse_dev(8'h1 << b);
            sweep("R5 device set", 0, 0, 1, 16'h0002);
            @(negedge clk); hw_mask = ~(8'h1 << b);
            #1 chk("R5 masked", int'(best_lvl), exp_lvl(int'(cur_ipl), 0, 0, 0, 0, 16'h0002));
            @(negedge clk); cur_ipl = 0; #1 chk("R5 masked ipl0", int'(best_lvl), 1);
            @(negedge clk); hw_mask = 8'hFF; #1 chk("R5 held", int'(best_lvl), 'h14);
            @(negedge clk); hw_clr = 8'h1 << b; @(negedge clk); hw_clr = 0;
            #1 chk("R5 cleared", int'(best_lvl), 1);
        end
        sw_req = 0;

        // R9 drain all devices under a partial mask, highest first
        pulse_dev(8'hFF);
        hw_mask = 8'b1010_0110;
        for (int b = 7; b >= 0; b--) begin
            if (hw_mask[b]) begin
                do_ack('h14, v, vv, ux);
                chk("R9 vec", v, 'h120 + 4 * b); chk("R9 valid", vv, 1);
            end
        end
        do_ack('h15, v, vv, ux);
        chk("R9 empty vec", v, 0); chk("R9 empty valid", vv, 1);
        @(negedge clk); hw_mask = 8'hFF; cur_ipl = 0;
        #1 chk("R9 masked bits kept", int'(best_lvl), 'h14);
        for (int b = 7; b >= 0; b--) begin
            if (b == 6 || b == 4 || b == 3 || b == 0) begin
                do_ack('h14, v, vv, ux);
                chk("R9 rest vec", v, 'h120 + 4 * b);
            end
        end
        @(negedge clk); #1 chk("R9 drained", int'(best_lvl), 0);

        // R10 unexpected levels
        pulse_dev(8'h10);
        for (int l = 'h18; l < 32; l++) begin
            if (l != 'h1A) begin
                do_ack(l, v, vv, ux);
                chk("R10 unexp", ux, 1); chk("R10 no valid", vv, 0); chk("R10 vec", v, 0);
                @(negedge clk); #1 chk("R10 one cycle", int'(unexp_irq), 0);
                chk("R10 request kept", int'(best_lvl), 'h14);
            end
        end
        do_ack('h14, v, vv, ux);
        chk("R11 vec after unexp", v, 'h130);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule